// File: doc/BRIEF.md
# Vector Lane-Sum Reduction Unit

This unit adds up all lanes of a packed vector operand. The result is a single scalar of the same lane width, and it wraps at that width. The caller picks the lane width with a 2-bit size code. A mode bit selects one of two forms:

- **Across-vector form.** Reduces either the low 64 bits or the full 128 bits of the operand, as chosen by a width bit.
- **Pairwise scalar form.** Adds two 64-bit lanes together.

The sum is built as a balanced binary tree. The tree splits the operand into lower and upper halves, reduces each half on its own, and adds the two partial sums.

Some combinations of lane width, mode and operand width are reserved. The unit flags these encodings and returns zero for them. For legal encodings, the scalar lands in the low lane bits of a 128-bit result and every bit above it is cleared. One request is accepted per cycle, and its result is registered with a single cycle of latency.

Top module: `radd_unit`

## Requirements
- R1: The lane width is 8 << size_i bits: size_i values 0, 1, 2 and 3 select 8, 16, 32 and 64-bit lanes.
- R2: With pairwise_i=0 and q_i=1, the result is the sum of all 128/ew lanes of vec_i, where lane k occupies bits [k*ew +: ew].
- R3: With pairwise_i=0 and q_i=0, only the 64/ew lanes in vec_i[63:0] are summed, and vec_i[127:64] has no effect on the result.
- R4: With pairwise_i=1 and size_i=3, the result is vec_i[63:0] + vec_i[127:64], and q_i has no effect.
- R5: Every partial sum wraps modulo 2^ew, so the reduced value is the lane sum truncated to ew bits.
- R6: The following encodings are reserved: pairwise_i=0 with size_i=3; pairwise_i=0 with size_i=2 and q_i=0; and pairwise_i=1 with any size_i other than 3. A reserved encoding sets undef_o=1 and result_o=0. Legal encodings give undef_o=0.
- R7: For a legal encoding, result_o bits at and above ew are zero.
- R8: A request presented with in_valid_i=1 at a rising clock edge appears on result_o and undef_o after that edge, with out_valid_o=1 for exactly that cycle. Back-to-back requests are accepted one per cycle.
- R9: While in_valid_i=0, result_o and undef_o hold their last values and out_valid_o is 0.
- R10: While rst_ni is low, out_valid_o, undef_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| vec_i | input | 128 | Packed vector operand |
| size_i | input | 2 | Lane width code |
| q_i | input | 1 | Across-vector operand width: 1 = 128 bits, 0 = 64 bits |
| pairwise_i | input | 1 | 1 selects the pairwise scalar form |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 128 | Zero-extended lane sum |
| undef_o | output | 1 | Reserved encoding was presented |

## Verification
Two things can happen on the same clock edge:

- Capturing a fresh legal sum.
- Squashing a reserved encoding to zero, which replaces the previous result.

The bench provokes this with back-to-back requests: a legal reduction, then immediately a reserved pairwise encoding. It checks that the first edge shows the legal sum with the flag low. It then checks that the next edge raises the flag and clears the result, with out_valid_o staying high throughout. Expected sums come from a per-lane accumulation loop in the bench, plus several hand-computed wrap cases.

// File: rtl/radd_pkg.sv
package radd_pkg;
  localparam int unsigned BASE_EW = 8;
  localparam int unsigned N_SIZES = 4;
  localparam int unsigned MAX_EW  = BASE_EW << (N_SIZES - 1);

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } lane_size_e;

  function automatic logic enc_reserved(input lane_size_e sz, input logic q, input logic pw);
    if (pw) return sz != SZ_64;
    return (sz == SZ_64) || (sz == SZ_32 && !q);
  endfunction
endpackage

// File: rtl/radd_tree.sv
// Balanced recursive lane adder: sum = reduce(lower half) + reduce(upper half).
module radd_tree #(
  parameter int unsigned ESIZE = 8,
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] opnd_i,
  output logic [ESIZE-1:0] sum_o
);
  if (WIDTH == ESIZE) begin : g_leaf
    assign sum_o = opnd_i;
  end else begin : g_split
    localparam int unsigned HALF = WIDTH / 2;
    logic [ESIZE-1:0] lo_sum, hi_sum;

    radd_tree #(.ESIZE(ESIZE), .WIDTH(HALF)) i_lo (
      .opnd_i(opnd_i[HALF-1:0]),
      .sum_o (lo_sum)
    );
    radd_tree #(.ESIZE(ESIZE), .WIDTH(HALF)) i_hi (
      .opnd_i(opnd_i[WIDTH-1:HALF]),
      .sum_o (hi_sum)
    );

    assign sum_o = lo_sum + hi_sum;  // wraps at ESIZE
  end
endmodule

// File: rtl/radd_select.sv
module radd_select
  import radd_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] vec_i,
  input  lane_size_e       size_i,
  input  logic             q_i,
  input  logic             pw_i,
  output logic [VEC_W-1:0] result_o,
  output logic             undef_o
);
  localparam int unsigned HALF_W = VEC_W / 2;

  logic [MAX_EW-1:0] full_ext [N_SIZES];
  logic [MAX_EW-1:0] half_ext [N_SIZES];
  logic [MAX_EW-1:0] pick;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_sz
    localparam int unsigned EW = BASE_EW << s;
    logic [EW-1:0] full_sum;

    radd_tree #(.ESIZE(EW), .WIDTH(VEC_W)) i_full (
      .opnd_i(vec_i),
      .sum_o (full_sum)
    );
    assign full_ext[s] = MAX_EW'(full_sum);

    if (EW < HALF_W) begin : g_half
      logic [EW-1:0] half_sum;
      radd_tree #(.ESIZE(EW), .WIDTH(HALF_W)) i_half (
        .opnd_i(vec_i[HALF_W-1:0]),
        .sum_o (half_sum)
      );
      assign half_ext[s] = MAX_EW'(half_sum);
    end else begin : g_nohalf
      assign half_ext[s] = '0;
    end
  end

  // pairwise form: two widest lanes = full-width tree at the widest size
  always_comb begin
    if (pw_i)     pick = full_ext[N_SIZES-1];
    else if (q_i) pick = full_ext[size_i];
    else          pick = half_ext[size_i];
  end

  assign undef_o  = enc_reserved(size_i, q_i, pw_i);
  assign result_o = undef_o ? '0 : VEC_W'(pick);
endmodule

// File: rtl/radd_unit.sv
module radd_unit
  import radd_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [127:0]     vec_i,
  input  logic [1:0]       size_i,
  input  logic             q_i,
  input  logic             pairwise_i,
  output logic             out_valid_o,
  output logic [127:0]     result_o,
  output logic             undef_o
);
  logic [VEC_W-1:0] res_d;
  logic             undef_d;

  radd_select #(.VEC_W(VEC_W)) i_select (
    .vec_i   (vec_i),
    .size_i  (lane_size_e'(size_i)),
    .q_i     (q_i),
    .pw_i    (pairwise_i),
    .result_o(res_d),
    .undef_o (undef_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      undef_o     <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= res_d;
        undef_o  <= undef_d;
      end
    end
  end

  // lane mask for the zero-extension check
  logic [VEC_W-1:0] keep_mask;
  assign keep_mask = ~({VEC_W{1'b1}} << (BASE_EW << size_i));

  assert_valid_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(result_o) && $stable(undef_o)));
  assert_zero_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ((result_o & ~$past(keep_mask)) == '0));
  assert_rsv_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && pairwise_i && size_i != 2'b11) |=> (undef_o && result_o == '0));
  assert_rsv_narrow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !pairwise_i && size_i == 2'b10 && !q_i) |=> undef_o);
  assert_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && pairwise_i && size_i == 2'b11) |=> !undef_o);
endmodule

// File: tb/test_radd_unit.sv
module test_radd_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] vec = '0;
  logic [1:0]   size = '0;
  logic         q = 1'b0;
  logic         pw = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         undef;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  radd_unit i_radd_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .vec_i(vec),
    .size_i(size), .q_i(q), .pairwise_i(pw),
    .out_valid_o(out_valid), .result_o(result), .undef_o(undef)
  );

  typedef struct packed {
    logic [127:0] v;
    logic [1:0]   s;
    logic         q;
    logic         pw;
  } stim_t;

  // R1: lane width from size code exercised across the table
  localparam stim_t TBL [13] = '{
    '{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 1'b0},
    '{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 1'b0},
    '{128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100, 2'd0, 1'b1, 1'b0},
    '{128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, 2'd1, 1'b1, 1'b0},
    '{128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, 2'd1, 1'b0, 1'b0},
    '{128'h8000_0001_7FFF_FFFF_DEAD_BEEF_0000_0010, 2'd2, 1'b1, 1'b0},
    '{128'h8000_0001_7FFF_FFFF_DEAD_BEEF_0000_0010, 2'd2, 1'b0, 1'b0},
    '{128'h0000_0000_0000_0001_0000_0000_0000_0002, 2'd3, 1'b1, 1'b0},
    '{128'h0123_4567_89AB_CDEF_1111_2222_3333_4444, 2'd3, 1'b1, 1'b1},
    '{128'h0123_4567_89AB_CDEF_1111_2222_3333_4444, 2'd0, 1'b1, 1'b1},
    '{128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b1},
    '{128'h0123_4567_89AB_CDEF_1111_2222_3333_4444, 2'd3, 1'b0, 1'b1},
    '{128'hAAAA_AAAA_AAAA_AAAA_5555_5555_5555_5555, 2'd3, 1'b0, 1'b0}
  };

  function automatic void ref_model(input logic [127:0] v, input logic [1:0] s,
                                    input logic qq, input logic p,
                                    output logic [127:0] r, output logic u);
    int ew;
    int w;
    logic [63:0] acc;
    logic [63:0] m;
    ew  = 8 << s;
    w   = p ? 2 * ew : (qq ? 128 : 64);
    u   = p ? (s != 2'd3) : (s == 2'd3 || (s == 2'd2 && !qq));
    m   = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    acc = '0;
    for (int e = 0; e < w / ew; e++) acc = acc + (64'(v >> (e * ew)) & m);
    r = u ? '0 : {64'b0, acc & m};
  endfunction

  function automatic string tag_of(input logic [1:0] s, input logic qq, input logic p);
    if (p ? (s != 2'd3) : (s == 2'd3 || (s == 2'd2 && !qq))) return "R6";
    if (p) return "R4";
    if (!qq) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] v, input logic [1:0] s,
                       input logic qq, input logic p);
    @(negedge clk);
    vec = v; size = s; q = qq; pw = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] er;
    logic         eu;
    logic [127:0] first;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "out_valid in reset", {127'b0, out_valid}, '0);
    chk("R10", "result in reset", result, '0);
    chk("R10", "undef in reset", {127'b0, undef}, '0);
    rst_n = 1'b1;

    foreach (TBL[i]) begin
      drive(TBL[i].v, TBL[i].s, TBL[i].q, TBL[i].pw);
      ref_model(TBL[i].v, TBL[i].s, TBL[i].q, TBL[i].pw, er, eu);
      chk(tag_of(TBL[i].s, TBL[i].q, TBL[i].pw), $sformatf("table %0d result", i), result, er);
      chk(tag_of(TBL[i].s, TBL[i].q, TBL[i].pw), $sformatf("table %0d undef", i),
          {127'b0, undef}, {127'b0, eu});
      chk("R8", $sformatf("table %0d out_valid", i), {127'b0, out_valid}, 128'd1);
    end

    // R5: wrap, 16 bytes of FF -> 0xF0, 8 halfwords of FFFF -> 0xFFF8
    drive('1, 2'd0, 1'b1, 1'b0);
    chk("R5", "byte wrap", result, 128'h0F0);
    drive('1, 2'd1, 1'b1, 1'b0);
    chk("R5", "half wrap", result, 128'hFFF8);
    drive({64'h1, 64'hFFFF_FFFF_FFFF_FFFF}, 2'd3, 1'b1, 1'b1);
    chk("R5", "pairwise wrap", result, '0);

    // R1: same operand, different lane width
    drive(128'h0000_0000_0000_0000_0000_0000_0102_0304, 2'd0, 1'b1, 1'b0);
    chk("R1", "8-bit lanes", result, 128'h0A);
    drive(128'h0000_0000_0000_0000_0000_0000_0102_0304, 2'd1, 1'b1, 1'b0);
    chk("R1", "16-bit lanes", result, 128'h0406);

    // R7: upper bits cleared
    drive('1, 2'd2, 1'b1, 1'b0);
    chk("R7", "upper bits zero", result >> 32, '0);
    chk("R7", "32-bit wrap", result, 128'hFFFF_FFFC);

    // R3: upper half ignored with q=0
    drive({64'h0, 64'h0102_0304_0506_0708}, 2'd0, 1'b0, 1'b0);
    first = result;
    drive({64'hFFEE_DDCC_BBAA_9988, 64'h0102_0304_0506_0708}, 2'd0, 1'b0, 1'b0);
    chk("R3", "upper half no effect", result, first);
    chk("R3", "narrow sum", first, 128'h24);

    // R4: q ignored in pairwise form
    drive({64'h10, 64'h20}, 2'd3, 1'b0, 1'b1);
    chk("R4", "pairwise q=0", result, 128'h30);
    drive({64'h10, 64'h20}, 2'd3, 1'b1, 1'b1);
    chk("R4", "pairwise q=1", result, 128'h30);

    // R9: hold while idle
    @(negedge clk);
    vec = '1; size = 2'd0; q = 1'b1; pw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "result held", result, 128'h30);
    chk("R9", "undef held", {127'b0, undef}, '0);
    chk("R9", "out_valid idle", {127'b0, out_valid}, '0);

    // R8/R6: back-to-back legal then reserved
    @(negedge clk);
    vec = 128'h0000_0000_0000_0000_0000_0000_0000_0505; size = 2'd0; q = 1'b0; pw = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R8", "b2b first result", result, 128'h0A);
    chk("R8", "b2b first undef", {127'b0, undef}, '0);
    vec = '1; size = 2'd1; q = 1'b1; pw = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6", "b2b reserved result", result, '0);
    chk("R6", "b2b reserved undef", {127'b0, undef}, 128'd1);
    chk("R8", "b2b out_valid", {127'b0, out_valid}, 128'd1);
    @(negedge clk);
    chk("R8", "out_valid drops", {127'b0, out_valid}, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule